// File: doc/BRIEF.md
# Bipolar Line Encoder with Error Injection

This block turns a unipolar transmit bit stream into a positive rail and a negative rail for a bipolar line. Ones are sent as alternate-mark-inversion pulses. Long runs of zeros are replaced by substitution code words that contain a deliberate violation pulse. In the three-zero mode (T3, `e3_mode` = 0) the code word is 00V or B0V. In the four-zero mode (E3, `e3_mode` = 1) it is 000V or B00V. When `uni_mode` is high, the block sends the bits straight through on the positive rail.

For line testing, two kinds of error can be armed. The first is a single bipolar violation, placed on the third of three consecutive ones. The second is a single excessive-zero event, made by leaving out the next substitution code word. In automatic mode an error is armed by a rising edge of its control bit. In manual mode it is armed by each toggle of a strobe, as long as its control bit is high. A one-cycle flag marks each injected error as it leaves on the rails.

The data input is a stream with a valid qualifier and no ready. Every cycle in which `in_valid` is high moves one bit in and one encoded symbol out, and the block never applies back-pressure. Cycles in which `in_valid` is low are idle. During idle cycles the encoder state and the rails hold, and the flags are low. Control inputs are plain levels, and `e3_mode`, `uni_mode` and `man_sel` are meant to be static while traffic flows.

Top module: `bpe_line_encoder`

## Requirements
- R1: In bipolar mode each input one leaves as a single pulse whose polarity is opposite to the previous pulse, and each unsubstituted zero leaves with both rails low. The rails are never high together. A bit accepted on valid beat k appears on the rails right after valid beat k+4. After reset, the first ordinary pulse is positive.
- R2: In T3 mode, three consecutive zeros that are still eligible for substitution are replaced. The replacement is 00V if an odd number of pulses has been sent since the last substitution, and B0V if that number is even. Here B is an ordinary alternating pulse and V is a pulse with the same polarity as the pulse before it.
- R3: In E3 mode, four eligible zeros are replaced by 000V when the pulse count since the last substitution is odd, and by B00V when it is even. The pulse count covers every pulse, including an injected violation.
- R4: In automatic mode (`man_sel` = 0), a 0-to-1 change of `bpv_ctl` arms one bipolar violation. The next input one that follows two consecutive ones is then sent with the same polarity as the previous pulse. Its beat raises `bpv_flag`, and later pulses alternate from it.
- R5: A 0-to-1 change of `exz_ctl` arms one excessive-zero event. The next substitution is skipped and its zeros are sent as plain zeros. The last zero of the skipped group raises `exz_flag`, and the parity count is left unchanged. Those zeros can never form part of a later substitution.
- R6: While `uni_mode` is high, `rail_pos` carries the input bit with the same latency and `rail_neg` stays low. No substitution happens, control edges and strobe toggles arm nothing, and both flags stay low.
- R7: In manual mode (`man_sel` = 1), every change of `man_strobe` arms one error of each type whose control bit is high. A control bit that is low arms nothing, and in this mode the rising edges of the control bits arm nothing.
- R8: A second arming event that comes while an error of the same type is still pending is merged into it, so only one error is injected.
- R9: In a cycle with `in_valid` low, both rails keep their values and both flags are low in the cycle that follows.
- R10: During reset and after it, before the first valid beat, both rails and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit valid; each high cycle is one beat |
| in_bit | input | 1 | Unipolar transmit bit |
| e3_mode | input | 1 | 0: three-zero substitution (T3), 1: four-zero substitution (E3) |
| uni_mode | input | 1 | 1: unipolar pass-through, no coding and no injection |
| bpv_ctl | input | 1 | Bipolar-violation insert control |
| exz_ctl | input | 1 | Excessive-zero insert control |
| man_sel | input | 1 | 0: arm on control rising edge, 1: arm on strobe toggle |
| man_strobe | input | 1 | Manual arming strobe, active on both edges |
| rail_pos | output | 1 | Positive rail |
| rail_neg | output | 1 | Negative rail |
| bpv_flag | output | 1 | One-cycle marker of an injected violation on the rails |
| exz_flag | output | 1 | Marker on the last zero of a skipped substitution |

## Verification
The hardest states to reach from the ports are those where an arm request meets its trigger at an awkward moment. An excessive-zero request may be pending while zero runs are longer than one code word. A violation request may be pending while a run of ones is already under way, or while a strobe toggles twice before the request is served. To get there, the stimulus draws data from a source that switches between mostly-zero, mixed and mostly-one bursts, so that long runs of each value come up often. It places arming events at random between beats. Directed sequences pin down the exact B0V/00V/B00V/000V choices, the polarity of the violation and the merge of two arming events, each with literal expected rail patterns.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
  // Kind of a symbol waiting in the lookahead window.
  // ZF: zero still eligible for substitution, ZS: zero that can no longer be substituted,
  // MK: ordinary alternating mark, VI: pulse with the same polarity as the one before.
  typedef enum logic [1:0] {
    SYM_ZF = 2'd0,
    SYM_ZS = 2'd1,
    SYM_MK = 2'd2,
    SYM_VI = 2'd3
  } sym_kind_e;

  typedef struct packed {
    sym_kind_e kind;
    logic      tag_bpv;
    logic      tag_exz;
  } sym_t;
endpackage

// File: rtl/bpe_arm.sv
module bpe_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl,
  input  logic man_sel,
  input  logic strobe,
  input  logic block,
  input  logic serve,
  output logic armed
);
  logic ctl_q;
  logic strobe_q;
  logic trig;

  // Auto mode arms on a rising edge of ctl; manual mode arms on any strobe change while ctl is high.
  always_comb begin
    trig = !block && ctl && (man_sel ? (strobe ^ strobe_q) : !ctl_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= 1'b0;
      strobe_q <= 1'b0;
      armed    <= 1'b0;
    end else begin
      ctl_q    <= ctl;
      strobe_q <= strobe;
      if (block)      armed <= 1'b0;
      else if (trig)  armed <= 1'b1;
      else if (serve) armed <= 1'b0;
    end
  end

  p_block_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    block |=> !armed);

  p_pending_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !serve && !block |=> armed);
endmodule

// File: rtl/bpe_subst.sv
module bpe_subst
  import bpe_pkg::*;
#(
  parameter int RUN_T3 = 3,
  parameter int RUN_E3 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic e3_mode,
  input  logic uni_mode,
  input  logic bpv_armed,
  input  logic exz_armed,
  output logic bpv_serve,
  output logic exz_serve,
  output sym_t head
);
  localparam int WIN = (RUN_E3 > RUN_T3) ? RUN_E3 : RUN_T3;

  sym_t       win_q [WIN];
  sym_t       win_d [WIN];
  logic       par_q;
  logic       par_d;
  logic [1:0] ones_q;
  logic       zero_run;
  int         run_len;

  always_comb begin
    run_len = e3_mode ? RUN_E3 : RUN_T3;
    win_d[0].kind    = in_bit ? SYM_MK : SYM_ZF;
    win_d[0].tag_bpv = 1'b0;
    win_d[0].tag_exz = 1'b0;
    for (int i = 1; i < WIN; i++) win_d[i] = win_q[i-1];
    bpv_serve = 1'b0;
    exz_serve = 1'b0;
    par_d     = par_q;
    zero_run  = 1'b0;
    if (in_valid && !uni_mode) begin
      // The third of three consecutive ones carries an armed violation.
      if (in_bit && bpv_armed && ones_q == 2'd2) begin
        win_d[0].kind    = SYM_VI;
        win_d[0].tag_bpv = 1'b1;
        bpv_serve        = 1'b1;
      end
      zero_run = 1'b1;
      for (int i = 0; i < WIN; i++) begin
        if (i < run_len && win_d[i].kind != SYM_ZF) zero_run = 1'b0;
      end
      if (zero_run) begin
        for (int i = 0; i < WIN; i++) begin
          if (i < run_len) win_d[i].kind = SYM_ZS;
        end
        if (exz_armed) begin
          win_d[0].tag_exz = 1'b1;
          exz_serve        = 1'b1;
        end else begin
          win_d[0].kind = SYM_VI;
          for (int i = 0; i < WIN; i++) begin
            if (i == run_len - 1 && !par_q) win_d[i].kind = SYM_MK;
          end
          par_d = 1'b0;
        end
      end else if (win_d[0].kind == SYM_MK || win_d[0].kind == SYM_VI) begin
        par_d = !par_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) begin
        win_q[i].kind    <= SYM_ZS;
        win_q[i].tag_bpv <= 1'b0;
        win_q[i].tag_exz <= 1'b0;
      end
      par_q  <= 1'b0;
      ones_q <= 2'd0;
    end else if (in_valid) begin
      for (int i = 0; i < WIN; i++) win_q[i] <= win_d[i];
      par_q  <= par_d;
      ones_q <= in_bit ? ((ones_q == 2'd2) ? 2'd2 : ones_q + 2'd1) : 2'd0;
    end
  end

  assign head = win_q[WIN-1];

  p_no_inject_uni_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uni_mode |-> !bpv_serve && !exz_serve);

  p_exz_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exz_serve |-> exz_armed && in_valid && !in_bit);
endmodule

// File: rtl/bpe_rail.sv
module bpe_rail
  import bpe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic uni_mode,
  input  sym_t head,
  output logic rail_pos,
  output logic rail_neg,
  output logic bpv_flag,
  output logic exz_flag
);
  logic last_pos;
  logic pulse;
  logic pol;

  always_comb begin
    pulse = (head.kind == SYM_MK) || (head.kind == SYM_VI);
    pol   = (head.kind == SYM_VI) ? last_pos : !last_pos;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rail_pos <= 1'b0;
      rail_neg <= 1'b0;
      bpv_flag <= 1'b0;
      exz_flag <= 1'b0;
      last_pos <= 1'b0;
    end else begin
      bpv_flag <= 1'b0;
      exz_flag <= 1'b0;
      if (in_valid) begin
        if (uni_mode) begin
          rail_pos <= pulse;
          rail_neg <= 1'b0;
        end else begin
          rail_pos <= pulse && pol;
          rail_neg <= pulse && !pol;
          if (pulse) last_pos <= pol;
          bpv_flag <= head.tag_bpv;
          exz_flag <= head.tag_exz;
        end
      end
    end
  end

  p_rails_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rail_pos && rail_neg));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(rail_pos) && $stable(rail_neg) && !bpv_flag && !exz_flag);

  p_bpv_is_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bpv_flag |-> rail_pos || rail_neg);

  p_exz_is_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exz_flag |-> !rail_pos && !rail_neg);

  p_uni_neg_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && uni_mode |=> !rail_neg && !bpv_flag && !exz_flag);
endmodule

// File: rtl/bpe_line_encoder.sv
module bpe_line_encoder
  import bpe_pkg::*;
#(
  parameter int RUN_T3 = 3,
  parameter int RUN_E3 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic e3_mode,
  input  logic uni_mode,
  input  logic bpv_ctl,
  input  logic exz_ctl,
  input  logic man_sel,
  input  logic man_strobe,
  output logic rail_pos,
  output logic rail_neg,
  output logic bpv_flag,
  output logic exz_flag
);
  localparam int NUM_ERR = 2;

  logic [NUM_ERR-1:0] ctl_v;
  logic [NUM_ERR-1:0] serve_v;
  logic [NUM_ERR-1:0] armed_v;
  logic bpv_serve;
  logic exz_serve;
  sym_t head;

  assign ctl_v   = {exz_ctl, bpv_ctl};
  assign serve_v = {exz_serve, bpv_serve};

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_arm
    bpe_arm u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl_v[g]),
      .man_sel (man_sel),
      .strobe  (man_strobe),
      .block   (uni_mode),
      .serve   (serve_v[g]),
      .armed   (armed_v[g])
    );
  end

  bpe_subst #(.RUN_T3(RUN_T3), .RUN_E3(RUN_E3)) u_subst (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .e3_mode   (e3_mode),
    .uni_mode  (uni_mode),
    .bpv_armed (armed_v[0]),
    .exz_armed (armed_v[1]),
    .bpv_serve (bpv_serve),
    .exz_serve (exz_serve),
    .head      (head)
  );

  bpe_rail u_rail (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .uni_mode (uni_mode),
    .head     (head),
    .rail_pos (rail_pos),
    .rail_neg (rail_neg),
    .bpv_flag (bpv_flag),
    .exz_flag (exz_flag)
  );

  p_serve_only_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bpv_serve |-> armed_v[0]);
endmodule

// File: tb/tb_bpe_line_encoder.sv
`timescale 1ns/1ps
module tb_bpe_line_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, e3_mode = 1'b0, uni_mode = 1'b0;
  logic bpv_ctl = 1'b0, exz_ctl = 1'b0, man_sel = 1'b0, man_strobe = 1'b0;
  logic rail_pos, rail_neg, bpv_flag, exz_flag;

  always #2 clk = ~clk;

  bpe_line_encoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .e3_mode(e3_mode), .uni_mode(uni_mode), .bpv_ctl(bpv_ctl), .exz_ctl(exz_ctl),
    .man_sel(man_sel), .man_strobe(man_strobe),
    .rail_pos(rail_pos), .rail_neg(rail_neg), .bpv_flag(bpv_flag), .exz_flag(exz_flag)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference model state. Kinds: 0 eligible zero, 1 held zero, 2 mark, 3 violation.
  int mw[4];
  bit mtb[4], mtx[4];
  bit mpar, mlast, marm_b, marm_x;
  int mones;
  bit ep, en, efb, efx;
  bit rec_p[$], rec_n[$], rec_b[$], rec_x[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int i = 0; i < 4; i++) begin mw[i] = 1; mtb[i] = 0; mtx[i] = 0; end
    mpar = 0; mlast = 0; marm_b = 0; marm_x = 0; mones = 0;
  endfunction

  function automatic void m_step(bit b);
    int  k = mw[3];
    bit  pl = (k >= 2);
    bit  pol = (k == 3) ? mlast : !mlast;
    int  n;
    bit  run;
    if (uni_mode) begin
      ep = pl; en = 0; efb = 0; efx = 0;
    end else begin
      ep = pl && pol; en = pl && !pol;
      if (pl) mlast = pol;
      efb = mtb[3]; efx = mtx[3];
    end
    for (int i = 3; i > 0; i--) begin mw[i] = mw[i-1]; mtb[i] = mtb[i-1]; mtx[i] = mtx[i-1]; end
    mw[0] = b ? 2 : 0; mtb[0] = 0; mtx[0] = 0;
    if (!uni_mode) begin
      if (b && marm_b && mones >= 2) begin mw[0] = 3; mtb[0] = 1; marm_b = 0; end
      n = e3_mode ? 4 : 3;
      run = 1;
      for (int i = 0; i < n; i++) if (mw[i] != 0) run = 0;
      if (run) begin
        for (int i = 0; i < n; i++) mw[i] = 1;
        if (marm_x) begin mtx[0] = 1; marm_x = 0; end
        else begin
          mw[0] = 3;
          if (!mpar) mw[n-1] = 2;
          mpar = 0;
        end
      end else if (mw[0] >= 2) mpar = !mpar;
    end
    mones = b ? ((mones < 2) ? mones + 1 : 2) : 0;
  endfunction

  task automatic beat(bit b);
    @(negedge clk); in_valid = 1'b1; in_bit = b;
    @(posedge clk); m_step(b);
    #1;
    chk({rail_pos, rail_neg} === {ep, en}, uni_mode ? "R6" : "R1", "rails",
        {rail_pos, rail_neg}, {ep, en});
    chk(bpv_flag === efb, "R4", "bpv_flag", bpv_flag, efb);
    chk(exz_flag === efx, "R5", "exz_flag", exz_flag, efx);
    rec_p.push_back(rail_pos); rec_n.push_back(rail_neg);
    rec_b.push_back(bpv_flag); rec_x.push_back(exz_flag);
  endtask

  // One idle cycle; "what" 0 none, 1 set bpv_ctl, 2 set exz_ctl, 3 toggle strobe.
  task automatic idle_op(int what, bit v);
    bit pp, pn, prev;
    pp = rail_pos; pn = rail_neg;
    @(negedge clk); in_valid = 1'b0;
    prev = 0;
    if (what == 1) begin prev = bpv_ctl; bpv_ctl = v; end
    if (what == 2) begin prev = exz_ctl; exz_ctl = v; end
    if (what == 3) man_strobe = ~man_strobe;
    @(posedge clk);
    if (!uni_mode) begin
      if (!man_sel && v && !prev && what == 1) marm_b = 1;
      if (!man_sel && v && !prev && what == 2) marm_x = 1;
      if (man_sel && what == 3) begin
        if (bpv_ctl) marm_b = 1;
        if (exz_ctl) marm_x = 1;
      end
    end
    #1;
    chk(rail_pos === pp && rail_neg === pn && !bpv_flag && !exz_flag, "R9", "idle hold",
        {rail_pos, rail_neg, bpv_flag, exz_flag}, {pp, pn, 2'b00});
  endtask

  task automatic do_reset(bit e3, bit uni, bit man);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; bpv_ctl = 1'b0; exz_ctl = 1'b0;
    man_strobe = 1'b0; e3_mode = e3; uni_mode = uni; man_sel = man;
    repeat (3) @(posedge clk);
    #1;
    chk({rail_pos, rail_neg, bpv_flag, exz_flag} === 4'b0, "R10", "in reset",
        {rail_pos, rail_neg, bpv_flag, exz_flag}, 0);
    @(negedge clk); rst_n = 1'b1;
    m_reset();
    rec_p.delete(); rec_n.delete(); rec_b.delete(); rec_x.delete();
    @(posedge clk); #1;
    chk({rail_pos, rail_neg, bpv_flag, exz_flag} === 4'b0, "R10", "after reset",
        {rail_pos, rail_neg, bpv_flag, exz_flag}, 0);
  endtask

  task automatic send(string bits);
    for (int i = 0; i < bits.len(); i++) beat(bits[i] == "1");
  endtask

  // Literal check of the rail pattern for the inputs since reset (4-beat latency).
  task automatic lit(string tag, string rails, string flags);
    send("1111");
    for (int i = 0; i < rails.len(); i++) begin
      bit xp, xn, xb, xx;
      xp = (rails[i] == "+"); xn = (rails[i] == "-");
      xb = (flags[i] == "b"); xx = (flags[i] == "x");
      chk({rec_p[i+4], rec_n[i+4], rec_b[i+4], rec_x[i+4]} === {xp, xn, xb, xx}, tag,
          "literal symbol", {rec_p[i+4], rec_n[i+4], rec_b[i+4], rec_x[i+4]}, {xp, xn, xb, xx});
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bias;
    void'($urandom(32'd20240611));
    // R2: B0V from reset (even count), then AMI.
    do_reset(0, 0, 0); send("0001111");
    lit("R2", "+0+-+-+", ".......");
    // R3: one mark then 000V.
    do_reset(1, 0, 0); send("100001");
    lit("R3", "+000+-", "......");
    // R4: violation on third one, same polarity as previous.
    do_reset(0, 0, 0); idle_op(1, 1); send("1111");
    lit("R4", "+--+", "..b.");
    // R5: skipped code word, then 00V with odd count.
    do_reset(0, 0, 0); idle_op(2, 1); send("1000000");
    lit("R5", "+00000+", "...x...");
    // R6: unipolar ignores arming.
    do_reset(1, 1, 0); idle_op(1, 1); idle_op(2, 1); send("1110000");
    lit("R6", "+++0000", ".......");
    // R7 and R8: manual strobe, low control arms nothing, two toggles give one error.
    do_reset(0, 0, 1); idle_op(3, 0); send("111");
    idle_op(1, 1); idle_op(3, 0); idle_op(3, 0); send("011111");
    lit("R7", "+-+0-++-+", "......b..");
    lit("R8", "+-+0-++-+", "......b..");

    // Constrained random phases against the model.
    for (int ph = 0; ph < 12; ph++) begin
      do_reset($urandom % 2, ($urandom % 4) == 0, ($urandom % 3) == 0);
      bias = 50;
      for (int op = 0; op < 400; op++) begin
        int r;
        r = $urandom % 100;
        if (op % 20 == 0) begin
          case ($urandom % 3)
            0: bias = 8;
            1: bias = 50;
            default: bias = 92;
          endcase
        end
        if (r < 4) idle_op(1 + ($urandom % 2), $urandom % 2);
        else if (r < 7) idle_op(3, 0);
        else if (r < 14) idle_op(0, 0);
        else beat(($urandom % 100) < bias);
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule